// File: doc/BRIEF.md
# Store Queue with Read Hazard Check

This block sits between a write-through cache and the next memory level. Stores from the processor are accepted into a small circular queue of address/data pairs and are written to memory one at a time, oldest first. The processor only stalls on a store when every slot is taken. Bursts of stores therefore cost no processor cycles as long as the queue has room.

A read miss arrives on a separate port and is held there until it can be sent to memory safely. The read address is compared, at block granularity, against every queued store in parallel. The read may also match a store that is being accepted in the same cycle. If nothing matches, the read goes to memory before any store still waiting in the queue. If something matches, stores keep draining until the last matching one has been written, and the read then goes ahead of the remaining younger stores. The memory side carries one request at a time and holds it until the memory acknowledges it.

Top module: `wr_buf`

## Requirements
- R1: After reset the queue is empty, `push_ready` is 1, and `mem_req_valid` and `rd_ready` are 0.
- R2: A store is taken in on a clock edge where `push_valid` and `push_ready` are both 1. The queue holds at most DEPTH stores, and while it holds DEPTH of them `push_ready` is 0 and no store is taken.
- R3: Stores are written to memory in the order they were taken. Each write request carries `mem_req_we`=1 and the address and data of the oldest queued store. The store leaves the queue on the edge where `mem_ack` is 1 for it, so one store is written per acknowledge.
- R4: Once `mem_req_valid` is 1, the request's `mem_req_we`, `mem_req_addr` and `mem_req_data` stay unchanged until the edge on which `mem_ack` is 1.
- R5: Two addresses match when they are equal in every bit except the low OFFS bits (OFFS=2 by default). The low bits select a word within a block and are ignored.
- R6: When the memory port is idle and a pending read matches no queued store, the next request is that read (`mem_req_we`=0, `mem_req_addr`=`rd_addr`), ahead of any queued stores.
- R7: When a pending read matches a queued store, it is not issued until that store and every store older than it have been written. The read is then issued before the younger, non-matching stores.
- R8: A store taken in on the same edge as a read decision counts as a match for that read, so the read is issued after that store is written.
- R9: `rd_ready` is 1 only during the cycle in which `mem_ack` acknowledges the read request, and the read is then complete.
- R10: A store taken in on the same edge that an acknowledge removes a store leaves the occupancy unchanged.
- R11: After each acknowledged request, `mem_req_valid` is 0 for one cycle before the next request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Processor offers a store |
| push_addr | input | AW | Store address |
| push_data | input | DW | Store data |
| push_ready | output | 1 | Queue can take a store this cycle |
| rd_valid | input | 1 | Read miss waiting to go to memory; held until `rd_ready` |
| rd_addr | input | AW | Read address; held stable while `rd_valid` is 1 |
| rd_ready | output | 1 | Read acknowledged by memory this cycle |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_we | output | 1 | 1 for a store write, 0 for a read |
| mem_req_addr | output | AW | Request address |
| mem_req_data | output | DW | Write data (zero for reads) |
| mem_ack | input | 1 | Memory accepts and completes the current request |

## Verification
A store taken in on edge N shows up as a write request after edge N+1: one edge updates the occupancy and the next is the arbiter's decision. A read that is clear of matches at a decision edge shows up as a request just after that edge. `rd_ready` rises in the same cycle as the read's acknowledge, and `mem_req_valid` is low in the cycle after any acknowledge. The bench drives inputs just after rising edges and samples on falling edges, with an extra small delay where a value depends on an acknowledge driven on that falling edge. It predicts the full order of memory transactions for each scenario, including an in-flight store that no read may overtake, and compares every acknowledged request against that prediction in a scoreboard.

// File: rtl/wr_buf_pkg.sv
package wr_buf_pkg;

    // Memory-side arbiter state
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_WRITE = 2'd1,
        ARB_READ  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/wr_buf_store.sv
// Circular storage of queued stores with head access and per-slot visibility
module wr_buf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_en,
    input  logic [AW-1:0]                push_addr,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop_en,
    output logic [AW-1:0]                head_addr,
    output logic [DW-1:0]                head_data,
    output logic [DEPTH-1:0][AW-1:0]     ent_addr,
    output logic [DEPTH-1:0]             ent_valid,
    output logic [CW-1:0]                count
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [DEPTH-1:0]         valid;
        logic [PW-1:0]            wr_ptr;
        logic [PW-1:0]            rd_ptr;
        logic [CW-1:0]            count;
    } store_t;

    store_t st_q, st_d;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (pop_en) begin
            st_d.valid[st_q.rd_ptr] = 1'b0;
            st_d.rd_ptr             = ptr_next(st_q.rd_ptr);
        end
        if (push_en) begin
            st_d.addr[st_q.wr_ptr]  = push_addr;
            st_d.data[st_q.wr_ptr]  = push_data;
            st_d.valid[st_q.wr_ptr] = 1'b1;
            st_d.wr_ptr             = ptr_next(st_q.wr_ptr);
        end
        unique case ({push_en, pop_en})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_addr = st_q.addr[st_q.rd_ptr];
    assign head_data = st_q.data[st_q.rd_ptr];
    assign ent_addr  = st_q.addr;
    assign ent_valid = st_q.valid;
    assign count     = st_q.count;

endmodule

// File: rtl/wr_buf_match.sv
// Parallel block-address comparison of a read against all queued stores
module wr_buf_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int OFFS  = 2
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0]         ent_valid,
    input  logic                     push_en,
    input  logic [AW-1:0]            push_addr,
    input  logic [AW-1:0]            rd_addr,
    output logic                     rd_hit
);

    localparam logic [AW-1:0] BLK_MASK = ~((AW'(1) << OFFS) - AW'(1));

    logic [DEPTH-1:0] slot_hit;
    logic             push_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign slot_hit[i] = ent_valid[i] &&
                             (((ent_addr[i] ^ rd_addr) & BLK_MASK) == '0);
    end

    // a store entering this cycle is treated as already queued
    assign push_hit = push_en && (((push_addr ^ rd_addr) & BLK_MASK) == '0);
    assign rd_hit   = (|slot_hit) || push_hit;

endmodule

// File: rtl/wr_buf_arb.sv
// Memory-side arbiter: one outstanding request, read first when hazard-free
module wr_buf_arb
    import wr_buf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_hit,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          mem_ack,
    output logic          mem_req_valid,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    output logic          rd_ready,
    output logic          pop_en
);

    typedef struct packed {
        arb_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } arb_t;

    arb_t arb_q, arb_d;

    always_comb begin
        arb_d    = arb_q;
        pop_en   = 1'b0;
        rd_ready = 1'b0;
        unique case (arb_q.st)
            ARB_IDLE: begin
                if (rd_valid && !rd_hit) begin
                    arb_d.st   = ARB_READ;
                    arb_d.addr = rd_addr;
                    arb_d.data = '0;
                end else if (count != '0) begin
                    arb_d.st   = ARB_WRITE;
                    arb_d.addr = head_addr;
                    arb_d.data = head_data;
                end
            end
            ARB_WRITE: begin
                if (mem_ack) begin
                    pop_en   = 1'b1;
                    arb_d.st = ARB_IDLE;
                end
            end
            ARB_READ: begin
                if (mem_ack) begin
                    rd_ready = 1'b1;
                    arb_d.st = ARB_IDLE;
                end
            end
            default: arb_d.st = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= '{st: ARB_IDLE, addr: '0, data: '0};
        end else begin
            arb_q <= arb_d;
        end
    end

    assign mem_req_valid = (arb_q.st != ARB_IDLE);
    assign mem_req_we    = (arb_q.st == ARB_WRITE);
    assign mem_req_addr  = arb_q.addr;
    assign mem_req_data  = arb_q.data;

endmodule

// File: rtl/wr_buf.sv
// Store queue between a write-through cache and memory, with read hazard check
module wr_buf #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int OFFS  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    output logic          mem_req_valid,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    input  logic          mem_ack
);

    localparam int CW = $clog2(DEPTH + 1);

    logic                     push_en;
    logic                     pop_en;
    logic                     rd_hit;
    logic [CW-1:0]            count;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0]         ent_valid;

    assign push_ready = (count != CW'(DEPTH));
    assign push_en    = push_valid && push_ready;

    wr_buf_store #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_addr (push_addr),
        .push_data (push_data),
        .pop_en    (pop_en),
        .head_addr (head_addr),
        .head_data (head_data),
        .ent_addr  (ent_addr),
        .ent_valid (ent_valid),
        .count     (count)
    );

    wr_buf_match #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .OFFS  (OFFS)
    ) u_match (
        .ent_addr  (ent_addr),
        .ent_valid (ent_valid),
        .push_en   (push_en),
        .push_addr (push_addr),
        .rd_addr   (rd_addr),
        .rd_hit    (rd_hit)
    );

    wr_buf_arb #(
        .AW (AW),
        .DW (DW),
        .CW (CW)
    ) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_valid      (rd_valid),
        .rd_addr       (rd_addr),
        .rd_hit        (rd_hit),
        .count         (count),
        .head_addr     (head_addr),
        .head_data     (head_data),
        .mem_ack       (mem_ack),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data),
        .rd_ready      (rd_ready),
        .pop_en        (pop_en)
    );

endmodule

// File: rtl/wr_buf_chk.sv
// Protocol and ordering properties, attached to wr_buf by bind
module wr_buf_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          rd_hit,
    input logic          mem_req_valid,
    input logic          mem_req_we,
    input logic [AW-1:0] mem_req_addr,
    input logic [DW-1:0] mem_req_data,
    input logic          mem_ack,
    input logic          push_en,
    input logic          pop_en,
    input logic [CW-1:0] count
);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_no_empty_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (count != '0));

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_we) &&
                                         $stable(mem_req_addr) && $stable(mem_req_data)));

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_valid) && !mem_req_we) |-> !$past(rd_hit));

    assert_read_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (rd_valid && mem_ack && mem_req_valid && !mem_req_we));

    assert_occupancy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en) |=> (count == $past(count)));

    assert_gap_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_ack) |=> !mem_req_valid);

endmodule

bind wr_buf wr_buf_chk #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_hit        (rd_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_data  (mem_req_data),
    .mem_ack       (mem_ack),
    .push_en       (push_en),
    .pop_en        (pop_en),
    .count         (count)
);

// File: tb/wr_buf_bench.sv
module wr_buf_bench;

    localparam int PERIOD  = 10;
    localparam int DEPTH   = 4;
    localparam int AW      = 16;
    localparam int DW      = 32;
    localparam int OFFS    = 2;
    localparam int ACK_LAT = 2;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } txn_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          push_valid;
    logic [AW-1:0] push_addr;
    logic [DW-1:0] push_data;
    logic          push_ready;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic          rd_ready;
    logic          mem_req_valid;
    logic          mem_req_we;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_data;
    logic          mem_ack;

    int   n_checks = 0;
    int   n_err    = 0;
    txn_t exp_q[$];
    bit   auto_ack = 1'b1;
    int   man_req  = 0;
    int   man_srv  = 0;
    int   wait_cnt = 0;

    always #(PERIOD/2) clk = ~clk;

    wr_buf #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW),
        .OFFS  (OFFS)
    ) u_wr_buf (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_valid    (push_valid),
        .push_addr     (push_addr),
        .push_data     (push_data),
        .push_ready    (push_ready),
        .rd_valid      (rd_valid),
        .rd_addr       (rd_addr),
        .rd_ready      (rd_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data),
        .mem_ack       (mem_ack)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic exp_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_q.push_back('{we: 1'b1, addr: a, data: d});
    endtask

    task automatic exp_rd(input logic [AW-1:0] a);
        exp_q.push_back('{we: 1'b0, addr: a, data: '0});
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            check("R11", "request gap after ack", 64'(mem_req_valid), 64'(0));
        end else if (mem_req_valid) begin
            bit go;
            if (auto_ack) begin
                wait_cnt++;
                go = (wait_cnt >= ACK_LAT);
            end else begin
                go = (man_req != man_srv);
                if (go) man_srv++;
            end
            if (go) begin
                wait_cnt = 0;
                if (exp_q.size() == 0) begin
                    check("R3", "unexpected request", 64'(mem_req_addr), 64'hffff_ffff);
                end else begin
                    txn_t e;
                    e = exp_q.pop_front();
                    check(e.we ? "R3" : "R6", "request kind", 64'(mem_req_we), 64'(e.we));
                    check(e.we ? "R3" : "R7", "request address", 64'(mem_req_addr), 64'(e.addr));
                    if (e.we) check("R3", "write data", 64'(mem_req_data), 64'(e.data));
                end
                mem_ack = 1'b1;
                #1;
                check("R9", "rd_ready at ack", 64'(rd_ready), 64'(!mem_req_we));
            end
        end
    end

    task automatic do_push(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        push_valid = 1'b1; push_addr = a; push_data = d;
        forever begin
            @(negedge clk);
            if (push_ready) break;
        end
        @(posedge clk); #1;
        push_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_addr = a;
        forever begin
            @(negedge clk); #2;
            if (rd_ready) break;
        end
        @(posedge clk); #1;
        rd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk); #3;
            if (exp_q.size() == 0 && !mem_req_valid && !mem_ack) break;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; push_valid = 1'b0; push_addr = '0; push_data = '0;
        rd_valid = 1'b0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1", "push_ready", 64'(push_ready), 64'(1));
        check("R1", "mem_req_valid", 64'(mem_req_valid), 64'(0));
        check("R1", "rd_ready", 64'(rd_ready), 64'(0));

        // R3: plain FIFO drain
        for (int i = 0; i < 3; i++) begin
            exp_wr(AW'(16'h0010 + 4*i), DW'(32'hA000_0000 + i));
            do_push(AW'(16'h0010 + 4*i), DW'(32'hA000_0000 + i));
        end
        wait_idle();

        // R2: fill to DEPTH, extra store refused, then drain across wrap
        auto_ack = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            exp_wr(AW'(16'h0040 + 4*i), DW'(32'hB000_0000 + i));
            do_push(AW'(16'h0040 + 4*i), DW'(32'hB000_0000 + i));
        end
        @(negedge clk);
        check("R2", "push_ready when full", 64'(push_ready), 64'(0));
        @(posedge clk); #1;
        push_valid = 1'b1; push_addr = 16'h0ff0; push_data = 32'hDEAD_BEEF;
        repeat (2) @(posedge clk);
        #1 push_valid = 1'b0;
        @(negedge clk);
        check("R2", "push_ready still low", 64'(push_ready), 64'(0));
        auto_ack = 1'b1;
        wait_idle();

        // R6: read with no match overtakes queued stores, not the in-flight one
        auto_ack = 1'b0;
        exp_wr(16'h0100, 32'hC000_0000);
        exp_rd(16'h0200);
        exp_wr(16'h0104, 32'hC000_0001);
        exp_wr(16'h0108, 32'hC000_0002);
        do_push(16'h0100, 32'hC000_0000);
        do_push(16'h0104, 32'hC000_0001);
        do_push(16'h0108, 32'hC000_0002);
        fork
            do_read(16'h0200);
            begin repeat (4) @(posedge clk); auto_ack = 1'b1; end
        join
        wait_idle();

        // R7, R5: read matches a middle store by block (offset bits differ)
        auto_ack = 1'b0;
        exp_wr(16'h0300, 32'hD000_0000);
        exp_wr(16'h0340, 32'hD000_0001);
        exp_rd(16'h0342);
        exp_wr(16'h0344, 32'hD000_0002);
        do_push(16'h0300, 32'hD000_0000);
        do_push(16'h0340, 32'hD000_0001);
        do_push(16'h0344, 32'hD000_0002);
        fork
            do_read(16'h0342);
            begin repeat (4) @(posedge clk); auto_ack = 1'b1; end
        join
        wait_idle();

        // R7, R5: read matches the youngest store, all stores go first
        auto_ack = 1'b0;
        exp_wr(16'h0500, 32'hE000_0000);
        exp_wr(16'h0504, 32'hE000_0001);
        exp_wr(16'h0508, 32'hE000_0002);
        exp_rd(16'h050B);
        do_push(16'h0500, 32'hE000_0000);
        do_push(16'h0504, 32'hE000_0001);
        do_push(16'h0508, 32'hE000_0002);
        fork
            do_read(16'h050B);
            begin repeat (4) @(posedge clk); auto_ack = 1'b1; end
        join
        wait_idle();

        // R8: store and read to one block arrive together on an empty queue
        exp_wr(16'h0700, 32'hF000_0000);
        exp_rd(16'h0701);
        fork
            do_push(16'h0700, 32'hF000_0000);
            do_read(16'h0701);
        join
        wait_idle();

        // R10: push on the same edge that an ack removes a store
        auto_ack = 1'b0;
        for (int i = 0; i < 5; i++) exp_wr(AW'(16'h0900 + 4*i), DW'(32'h1111_0000 + i));
        for (int i = 0; i < 3; i++) do_push(AW'(16'h0900 + 4*i), DW'(32'h1111_0000 + i));
        @(posedge clk); #1;
        push_valid = 1'b1; push_addr = 16'h090C; push_data = 32'h1111_0003;
        man_req++;
        @(posedge clk); #1;
        push_valid = 1'b0;
        @(negedge clk);
        check("R10", "push_ready after push+drain", 64'(push_ready), 64'(1));
        do_push(16'h0910, 32'hC1C1_0004 ^ 32'hD0D0_0000);
        @(negedge clk);
        check("R2", "push_ready full after refill", 64'(push_ready), 64'(0));
        auto_ack = 1'b1;
        wait_idle();

        finish_run();
    end

endmodule